// File: doc/BRIEF.md
# Auto-reload down-counting interrupt timer

This block is one timer channel: a counter that decrements on a selectable tick enable and raises an interrupt level when it counts down past zero. Two tick enables come in from outside, one fast and one slow, and a control bit picks which one drives the count. In periodic mode the counter refills from its load register on underflow. In free-running mode it wraps to all ones. The interrupt stays set until software writes any value to the clear word.

Software uses a plain register port. Writing the load word also restarts the counter from the new value. To re-arm a single event, software writes control with enable low, then the load value, then control with enable high. The counter width is a parameter, 16 or 32 bits, so the same block serves narrow and wide channels.

Top module: `irq_down_timer`

## Requirements
- R1: After reset the load, value and control words read zero and `irq` is low.
- R2: The word at byte offset 0x0 holds the load value. Writing it copies the low WIDTH bits of `wdata` into the counter in the same clock, and reading it returns the stored value.
- R3: The word at byte offset 0x8 is control. Bit 7 is enable, bit 6 is periodic mode and bit 3 is fast-tick select. It reads back with every other bit zero.
- R4: When enabled, the counter drops by one on each clock where the selected tick is high: `tick_fast` when bit 3 is 1, `tick_slow` when bit 3 is 0. The unselected tick has no effect.
- R5: With enable at 0 the counter holds its value whatever the ticks do.
- R6: In periodic mode, a selected tick while the counter is 0 reloads it from the load word and sets `irq`.
- R7: In free-running mode, a selected tick while the counter is 0 wraps it to all ones (0xFFFF at WIDTH 16) and sets `irq`.
- R8: `irq` stays high until a write of any data to byte offset 0xC, which clears it on the next clock. That word reads zero.
- R9: If an underflow and a clear write fall on the same clock, `irq` stays set. A clear on a tick clock that does not underflow still clears it.
- R10: The word at byte offset 0x4 returns the live counter. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast tick enable, one clock per tick |
| tick_slow | input | 1 | Slow tick enable, one clock per tick |
| addr | input | 4 | Byte offset of the register word |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Sticky underflow interrupt level |

## Verification
A wrong count or a wrong reload shows on the value word as soon as it is read. Underflow then comes early or late, and `irq` rises at the wrong clock by as many ticks as the count is off. A wrong tick selection or enable shows as a value that moves when it should hold, or holds when it should move, on the first tick after the control write. A mishandled clear shows on `irq` one clock after the clear write, and the case where a clear and an underflow fall on the same clock is driven directly.

// File: rtl/irq_down_timer.sv
module irq_down_timer #(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [3:0] OFS_LOAD = 4'h0;
  localparam logic [3:0] OFS_VAL  = 4'h4;
  localparam logic [3:0] OFS_CTL  = 4'h8;
  localparam logic [3:0] OFS_CLR  = 4'hC;
  localparam int BIT_EN = 7;
  localparam int BIT_PER = 6;
  localparam int BIT_FAST = 3;

  logic [WIDTH-1:0] count_q, load_q;
  logic en_q, per_q, fast_q, irq_q;

  wire load_wr = wr_en && addr == OFS_LOAD;
  wire ctl_wr  = wr_en && addr == OFS_CTL;
  wire clr_wr  = wr_en && addr == OFS_CLR;
  wire step    = en_q && (fast_q ? tick_fast : tick_slow);
  wire at_zero = count_q == '0;
  wire uflow   = step && at_zero && !load_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      if (load_wr) load_q <= wdata[WIDTH-1:0];
      if (ctl_wr) begin
        en_q   <= wdata[BIT_EN];
        per_q  <= wdata[BIT_PER];
        fast_q <= wdata[BIT_FAST];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (load_wr)
      count_q <= wdata[WIDTH-1:0];
    else if (uflow)
      count_q <= per_q ? load_q : '1;
    else if (step)
      count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (uflow)  irq_q <= 1'b1;
    else if (clr_wr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_LOAD: rdata = 32'(load_q);
      OFS_VAL:  rdata = 32'(count_q);
      OFS_CTL:  begin
        rdata[BIT_EN]   = en_q;
        rdata[BIT_PER]  = per_q;
        rdata[BIT_FAST] = fast_q;
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_down_timer_props.sv
module irq_down_timer_props #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_fast,
  input logic             tick_slow,
  input logic [3:0]       addr,
  input logic             wr_en,
  input logic             irq,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] ld,
  input logic             en,
  input logic             per,
  input logic             fast
);
  logic lw, cw, tk, uf;
  assign lw = wr_en && addr == 4'h0;
  assign cw = wr_en && addr == 4'hC;
  assign tk = en && (fast ? tick_fast : tick_slow);
  assign uf = tk && cnt == '0 && !lw;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    lw |=> cnt == ld); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    tk && cnt != '0 && !lw |=> cnt == $past(cnt) - WIDTH'(1)); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !lw |=> $stable(cnt)); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf && per |=> cnt == $past(ld) && irq); // R6
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    uf && !per |=> cnt == '1 && irq); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cw |=> irq); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cw && !uf |=> !irq); // R9
  AST_UF_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cw && uf |=> irq); // R9
endmodule

bind irq_down_timer irq_down_timer_props #(.WIDTH(WIDTH)) u_props (
  .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
  .addr(addr), .wr_en(wr_en), .irq(irq), .cnt(count_q), .ld(load_q),
  .en(en_q), .per(per_q), .fast(fast_q)
);

// File: tb/irq_down_timer_test.sv
module irq_down_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_fast = 1'b0, tick_slow = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  typedef struct { bit is_irq; logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  irq_down_timer #(.WIDTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    sb.push_back('{1'b0, e, r});
    #4;
  endtask

  task automatic expect_irq(input bit e, input string r);
    @(negedge clk);
    sb.push_back('{1'b1, {31'd0, e}, r});
    #4;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic tick_and_clear;
    @(negedge clk);
    tick_fast = 1'b1; addr = 4'hC; wdata = 32'h0; wr_en = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(4'h0, 32'h0, "R1 load");
    expect_rd(4'h4, 32'h0, "R1 value");
    expect_rd(4'h8, 32'h0, "R1 control");
    expect_irq(1'b0, "R1 irq");

    wr(4'h0, 32'hABCD_0005);
    expect_rd(4'h4, 32'h5, "R2 value after load");
    expect_rd(4'h0, 32'h5, "R2 load readback");

    wr(4'h8, 32'hFFFF_FFFF);
    expect_rd(4'h8, 32'hC8, "R3 control readback");
    wr(4'h8, 32'h0000_00C8);

    pulse(1'b0, 3);
    expect_rd(4'h4, 32'h5, "R4 slow tick ignored");
    pulse(1'b1, 2);
    expect_rd(4'h4, 32'h3, "R4 fast decrement");

    wr(4'h8, 32'h48);
    pulse(1'b1, 2);
    expect_rd(4'h4, 32'h3, "R5 disabled hold");

    wr(4'h8, 32'hC8);
    pulse(1'b1, 3);
    expect_rd(4'h4, 32'h0, "R6 reached zero");
    expect_irq(1'b0, "R6 no irq at zero");
    pulse(1'b1, 1);
    expect_rd(4'h4, 32'h5, "R6 reload");
    expect_irq(1'b1, "R6 irq set");

    pulse(1'b1, 2);
    expect_irq(1'b1, "R8 sticky");
    wr(4'hC, 32'h0);
    expect_irq(1'b0, "R8 cleared");
    expect_rd(4'hC, 32'h0, "R8 clear reads zero");

    wr(4'h4, 32'h1234);
    expect_rd(4'h4, 32'h3, "R10 value write ignored");

    wr(4'h8, 32'h80);
    wr(4'h0, 32'h1);
    pulse(1'b1, 2);
    expect_rd(4'h4, 32'h1, "R4 fast ignored in slow mode");
    pulse(1'b0, 1);
    expect_irq(1'b0, "R7 no irq at zero");
    pulse(1'b0, 1);
    expect_rd(4'h4, 32'hFFFF, "R7 wrap");
    expect_irq(1'b1, "R7 irq set");
    wr(4'hC, 32'h5A5A_5A5A);
    expect_irq(1'b0, "R8 clear any data");

    wr(4'h0, 32'h2);
    wr(4'h8, 32'hC8);
    pulse(1'b1, 2);
    expect_rd(4'h4, 32'h0, "R9 at zero");
    tick_and_clear;
    expect_irq(1'b1, "R9 underflow beats clear");
    expect_rd(4'h4, 32'h2, "R9 reload");
    tick_and_clear;
    expect_irq(1'b0, "R9 clear without underflow");
    expect_rd(4'h4, 32'h1, "R9 decrement");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule